// File: doc/BRIEF.md
# Vertical-Blank NMI and Beam IRQ Controller

This block sits beside a video timing generator and watches the beam position it reports. When the generator signals that vertical blanking has begun, the block sets a "vblank occurred" flag in a readable status byte, captures the forced-blank request from the display control register, and, if the CPU has enabled the vertical-blank interrupt, schedules an NMI that is raised at a fixed horizontal position on that same line. When the frame wraps back to line 0, the flag is withdrawn and any NMI that is pending or asserted is cancelled.

The same block also produces a beam-match IRQ. There are three ways to trigger it. In the first, the line compare alone is armed and the IRQ fires at the start of the matching line. In the second, the dot compare alone is armed and it fires at that dot on every line. In the third, both are armed and it fires at that dot on the matching line only. Once raised, the IRQ stays asserted until the CPU acknowledges it. The status byte carries a fixed chip version number in its low bits. Reading the status byte clears the vblank flag and leaves the version bits alone.

Top module: `vblank_irq_ctrl`

## Requirements
- R1: One cycle after a `vblank_start` pulse (without `frame_wrap`), `status` equals 0x80 OR the version number. Bit 7 is the vblank flag and bits [VER_W-1:0] hold VERSION. With the defaults this is 0x82.
- R2: If `nmi_en` is 1 in the `vblank_start` cycle, `nmi_out` goes high in the cycle after `h_count` equals NMI_HPOS (12) on that line. If `nmi_en` is 0 at that moment, no NMI is raised in that frame.
- R3: One cycle after a `frame_wrap` pulse, `status` equals the version alone (0x02), `nmi_out` is low, and an NMI that has not yet fired is cancelled. `frame_wrap` wins over a `vblank_start` in the same cycle.
- R4: `fblank` takes the value of `disp_blank` (bit 7 of the display control register) in the `vblank_start` cycle. At all other times it holds its value.
- R5: With `vtmr_en`=1 and `htmr_en`=0, `irq_out` rises one cycle after a cycle with `h_count`=0 and `v_count`=`v_cmp`. A line match at any other dot does not raise it.
- R6: With `htmr_en`=1, `irq_out` rises one cycle after `h_count`=`h_cmp`. This happens on every line when `vtmr_en`=0, and only on the line where `v_count`=`v_cmp` when `vtmr_en`=1.
- R7: `irq_out` stays high until a cycle with `irq_clr`=1 and drops one cycle later. A new match in the same cycle as `irq_clr` keeps it high.
- R8: One cycle after a `status_rd` strobe, bit 7 of `status` is 0 and the version bits are unchanged. A `vblank_start` in the same cycle wins and leaves the flag set.
- R9: After reset, `nmi_out`=0, `irq_out`=0, `fblank`=0 and `status` equals the version (0x02).
- R10: With `htmr_en`=0 and `vtmr_en`=0, `irq_out` never rises, whatever the beam position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_count | input | HW | Current dot position in the line |
| v_count | input | VW | Current line number |
| vblank_start | input | 1 | One-cycle pulse at dot 0 of the first blanked line |
| frame_wrap | input | 1 | One-cycle pulse when the line count returns to 0 |
| nmi_en | input | 1 | Vblank NMI enable (bit 7 of the NMI enable register) |
| disp_blank | input | 1 | Forced-blank request (bit 7 of the display control register) |
| htmr_en | input | 1 | Dot compare enable |
| vtmr_en | input | 1 | Line compare enable |
| h_cmp | input | HW | Dot compare position |
| v_cmp | input | VW | Line compare position |
| status_rd | input | 1 | Status byte read strobe |
| irq_clr | input | 1 | IRQ acknowledge strobe |
| nmi_out | output | 1 | NMI request line |
| irq_out | output | 1 | Beam-match IRQ line |
| status | output | 8 | Vblank flag in bit 7, version number in the low bits |
| fblank | output | 1 | Forced-blank bit latched at vblank start |

## Verification
The NMI path is driven through a full line with the enable set, with the enable clear, and with a frame wrap arriving before dot 12. These cases separate a correctly sampled and cancelled request from one that fires late, fires anyway, or survives the wrap. The IRQ is driven in each of the four timer-enable combinations. In each, some beam positions match only one of the two compares, so a mode that ignores the line, or fires away from dot 0, shows up. Coincident strobes test which one wins: wrap against vblank start, read against vblank start, and acknowledge against a new match.

// File: rtl/vblank_irq_pkg.sv
package vblank_irq_pkg;

    // Beam IRQ trigger mode derived from the two timer enables.
    typedef enum logic [1:0] {
        IRQ_OFF    = 2'b00,
        IRQ_LINE   = 2'b01,
        IRQ_DOT    = 2'b10,
        IRQ_DOTLN  = 2'b11
    } irq_mode_e;

    function automatic irq_mode_e decode_mode(input logic h_en, input logic v_en);
        return irq_mode_e'({h_en, v_en});
    endfunction

endpackage

// File: rtl/vbl_status_reg.sv
// Holds the vblank flag, the status byte and the latched forced-blank bit.
// Assumes vblank_start and frame_wrap are single-cycle pulses; the wrap
// takes priority, and a vblank start beats a simultaneous read.
module vbl_status_reg #(
    parameter int VER_W   = 4,
    parameter int VERSION = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vblank_start,
    input  logic       frame_wrap,
    input  logic       status_rd,
    input  logic       disp_blank,
    output logic [7:0] status,
    output logic       fblank
);
    localparam int PAD_W = 7 - VER_W;
    localparam logic [VER_W-1:0] VER_BITS = VER_W'(VERSION);

    logic flag_q;

    // Vblank-occurred flag: set at vblank start, cleared by wrap or read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (frame_wrap)
            flag_q <= 1'b0;
        else if (vblank_start)
            flag_q <= 1'b1;
        else if (status_rd)
            flag_q <= 1'b0;
    end

    // Forced-blank capture at vblank start only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fblank <= 1'b0;
        else if (vblank_start && !frame_wrap)
            fblank <= disp_blank;
    end

    // Status byte assembly; the padding between flag and version depends on VER_W.
    generate
        if (PAD_W > 0) begin : g_pad
            assign status = {flag_q, {PAD_W{1'b0}}, VER_BITS};
        end else begin : g_nopad
            assign status = {flag_q, VER_BITS};
        end
    endgenerate

endmodule

// File: rtl/nmi_sched.sv
// Schedules the vblank NMI: armed at vblank start when enabled, raised
// when the dot count reaches NMI_HPOS, dropped and disarmed at frame wrap.
// Assumes the timing generator delivers vblank_start at a dot below NMI_HPOS.
module nmi_sched #(
    parameter int HW       = 11,
    parameter int NMI_HPOS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_count,
    input  logic          vblank_start,
    input  logic          frame_wrap,
    input  logic          nmi_en,
    output logic          nmi_out
);
    localparam logic [HW-1:0] FIRE_H = HW'(NMI_HPOS);

    logic armed_q;
    logic fire;

    // Fire point: armed and the beam has reached the NMI dot.
    always_comb fire = armed_q && (h_count == FIRE_H);

    // Arm register: captures the enable at vblank start, consumed on fire.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (frame_wrap)
            armed_q <= 1'b0;
        else if (vblank_start)
            armed_q <= nmi_en;
        else if (fire)
            armed_q <= 1'b0;
    end

    // NMI line: set on fire, held until the frame wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_out <= 1'b0;
        else if (frame_wrap)
            nmi_out <= 1'b0;
        else if (fire)
            nmi_out <= 1'b1;
    end

endmodule

// File: rtl/beam_irq.sv
// Beam-match IRQ: compares the beam against the dot and line positions
// in the mode picked by the two timer enables, and holds the request
// until acknowledged. A new match beats a simultaneous acknowledge.
module beam_irq
    import vblank_irq_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_count,
    input  logic [VW-1:0] v_count,
    input  logic          htmr_en,
    input  logic          vtmr_en,
    input  logic [HW-1:0] h_cmp,
    input  logic [VW-1:0] v_cmp,
    input  logic          irq_clr,
    output logic          irq_out
);
    irq_mode_e mode;
    logic      line_hit;
    logic      dot_hit;
    logic      hit;

    // Match decode per trigger mode.
    always_comb begin
        mode     = decode_mode(htmr_en, vtmr_en);
        line_hit = (v_count == v_cmp);
        dot_hit  = (h_count == h_cmp);
        unique case (mode)
            IRQ_OFF:   hit = 1'b0;
            IRQ_LINE:  hit = line_hit && (h_count == '0);
            IRQ_DOT:   hit = dot_hit;
            IRQ_DOTLN: hit = dot_hit && line_hit;
            default:   hit = 1'b0;
        endcase
    end

    // Request latch: set on match, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else if (hit)
            irq_out <= 1'b1;
        else if (irq_clr)
            irq_out <= 1'b0;
    end

endmodule

// File: rtl/vblank_irq_ctrl.sv
// Top level: vblank status/NMI controller plus beam-match IRQ.
// Assumes h_count/v_count come from a timing generator in the same clock
// domain and that the strobes are one cycle wide.
module vblank_irq_ctrl #(
    parameter int HW       = 11,
    parameter int VW       = 9,
    parameter int NMI_HPOS = 12,
    parameter int VER_W    = 4,
    parameter int VERSION  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_count,
    input  logic [VW-1:0] v_count,
    input  logic          vblank_start,
    input  logic          frame_wrap,
    input  logic          nmi_en,
    input  logic          disp_blank,
    input  logic          htmr_en,
    input  logic          vtmr_en,
    input  logic [HW-1:0] h_cmp,
    input  logic [VW-1:0] v_cmp,
    input  logic          status_rd,
    input  logic          irq_clr,
    output logic          nmi_out,
    output logic          irq_out,
    output logic [7:0]    status,
    output logic          fblank
);

    vbl_status_reg #(.VER_W(VER_W), .VERSION(VERSION)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .vblank_start (vblank_start),
        .frame_wrap   (frame_wrap),
        .status_rd    (status_rd),
        .disp_blank   (disp_blank),
        .status       (status),
        .fblank       (fblank)
    );

    nmi_sched #(.HW(HW), .NMI_HPOS(NMI_HPOS)) u_nmi (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_count      (h_count),
        .vblank_start (vblank_start),
        .frame_wrap   (frame_wrap),
        .nmi_en       (nmi_en),
        .nmi_out      (nmi_out)
    );

    beam_irq #(.HW(HW), .VW(VW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_count  (h_count),
        .v_count  (v_count),
        .htmr_en  (htmr_en),
        .vtmr_en  (vtmr_en),
        .h_cmp    (h_cmp),
        .v_cmp    (v_cmp),
        .irq_clr  (irq_clr),
        .irq_out  (irq_out)
    );

endmodule

// File: rtl/vblank_irq_ctrl_chk.sv
// Property checker for vblank_irq_ctrl, attached by bind.
module vblank_irq_ctrl_chk #(
    parameter int HW       = 11,
    parameter int NMI_HPOS = 12,
    parameter int VER_W    = 4,
    parameter int VERSION  = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] h_count,
    input logic          vblank_start,
    input logic          frame_wrap,
    input logic          disp_blank,
    input logic          htmr_en,
    input logic          vtmr_en,
    input logic          status_rd,
    input logic          irq_clr,
    input logic          nmi_out,
    input logic          irq_out,
    input logic [7:0]    status,
    input logic          fblank
);
    localparam logic [HW-1:0]    FIRE_H   = HW'(NMI_HPOS);
    localparam logic [VER_W-1:0] VER_BITS = VER_W'(VERSION);

    assert_vbl_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && !frame_wrap) |=> status[7]);

    assert_nmi_at_dot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_out) |-> ($past(h_count) == FIRE_H));

    assert_wrap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (!nmi_out && !status[7]));

    assert_fblank_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && !frame_wrap) |=> (fblank == $past(disp_blank)));

    assert_fblank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_start |=> $stable(fblank));

    assert_irq_needs_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(htmr_en || vtmr_en));

    assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !irq_clr) |=> irq_out);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !vblank_start) |=> !status[7]);

    // R9: version bits never change once out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            assert_version_const_R9: assert (status[VER_W-1:0] == VER_BITS);
        end
    end

endmodule

bind vblank_irq_ctrl vblank_irq_ctrl_chk #(
    .HW(HW), .NMI_HPOS(NMI_HPOS), .VER_W(VER_W), .VERSION(VERSION)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_count      (h_count),
    .vblank_start (vblank_start),
    .frame_wrap   (frame_wrap),
    .disp_blank   (disp_blank),
    .htmr_en      (htmr_en),
    .vtmr_en      (vtmr_en),
    .status_rd    (status_rd),
    .irq_clr      (irq_clr),
    .nmi_out      (nmi_out),
    .irq_out      (irq_out),
    .status       (status),
    .fblank       (fblank)
);

// File: tb/vblank_irq_ctrl_bench.sv
module vblank_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 11;
    localparam int VW = 9;
    localparam logic [7:0] ST_IDLE = 8'h02;
    localparam logic [7:0] ST_VBL  = 8'h82;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] h_count = '0;
    logic [VW-1:0] v_count = '0;
    logic          vblank_start = 1'b0, frame_wrap = 1'b0;
    logic          nmi_en = 1'b0, disp_blank = 1'b0;
    logic          htmr_en = 1'b0, vtmr_en = 1'b0;
    logic [HW-1:0] h_cmp = '0;
    logic [VW-1:0] v_cmp = '0;
    logic          status_rd = 1'b0, irq_clr = 1'b0;
    logic          nmi_out, irq_out, fblank;
    logic [7:0]    status;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vblank_irq_ctrl u_vblank_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
        .vblank_start(vblank_start), .frame_wrap(frame_wrap), .nmi_en(nmi_en),
        .disp_blank(disp_blank), .htmr_en(htmr_en), .vtmr_en(vtmr_en),
        .h_cmp(h_cmp), .v_cmp(v_cmp), .status_rd(status_rd), .irq_clr(irq_clr),
        .nmi_out(nmi_out), .irq_out(irq_out), .status(status), .fblank(fblank)
    );

    // Compare one value and log a failure line when it differs.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present one beam position for one clock, then drop all strobes.
    task automatic step(input int h, input int v);
        h_count = HW'(h);
        v_count = VW'(v);
        @(posedge clk);
        #(CLK_PERIOD/4);
        vblank_start = 1'b0;
        frame_wrap   = 1'b0;
        status_rd    = 1'b0;
        irq_clr      = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 nmi", int'(nmi_out), 0);
        check("R9 irq", int'(irq_out), 0);
        check("R9 fblank", int'(fblank), 0);
        check("R9 status", int'(status), int'(ST_IDLE));
    endtask

    task automatic t_vblank_nmi();
        nmi_en = 1'b1; disp_blank = 1'b1; vblank_start = 1'b1;
        step(0, 225);
        check("R1 status at vblank", int'(status), int'(ST_VBL));
        check("R4 fblank captured", int'(fblank), 1);
        for (int h = 1; h < 12; h++) step(h, 225);
        check("R2 nmi before dot 12", int'(nmi_out), 0);
        step(12, 225);
        check("R2 nmi at dot 12", int'(nmi_out), 1);
        status_rd = 1'b1;
        step(13, 225);
        check("R8 read clears flag", int'(status), int'(ST_IDLE));
        check("R2 nmi held", int'(nmi_out), 1);
        frame_wrap = 1'b1;
        step(0, 0);
        check("R3 nmi dropped at wrap", int'(nmi_out), 0);
        check("R3 status at wrap", int'(status), int'(ST_IDLE));
    endtask

    task automatic t_nmi_disabled();
        nmi_en = 1'b0; disp_blank = 1'b0; vblank_start = 1'b1;
        step(0, 225);
        check("R4 fblank cleared", int'(fblank), 0);
        for (int h = 1; h < 16; h++) step(h, 225);
        check("R2 no nmi when disabled", int'(nmi_out), 0);
        disp_blank = 1'b1;
        step(16, 225);
        check("R4 fblank holds", int'(fblank), 0);
        frame_wrap = 1'b1;
        step(0, 0);
    endtask

    task automatic t_wrap_cancels();
        nmi_en = 1'b1; vblank_start = 1'b1;
        step(0, 225);
        for (int h = 1; h < 6; h++) step(h, 225);
        frame_wrap = 1'b1;
        step(6, 0);
        for (int h = 7; h < 15; h++) step(h, 0);
        check("R3 pending nmi cancelled", int'(nmi_out), 0);
    endtask

    task automatic t_coincident_strobes();
        vblank_start = 1'b1; frame_wrap = 1'b1;
        step(0, 0);
        check("R3 wrap beats vblank", int'(status), int'(ST_IDLE));
        vblank_start = 1'b1; status_rd = 1'b1;
        step(0, 225);
        check("R8 vblank beats read", int'(status), int'(ST_VBL));
        frame_wrap = 1'b1;
        step(0, 0);
    endtask

    task automatic t_irq_line();
        vtmr_en = 1'b1; htmr_en = 1'b0; v_cmp = 9'd50;
        step(0, 49);
        check("R5 no irq off line", int'(irq_out), 0);
        step(5, 50);
        check("R5 no irq away from dot 0", int'(irq_out), 0);
        step(0, 50);
        check("R5 irq at line start", int'(irq_out), 1);
        step(1, 50);
        check("R7 irq held", int'(irq_out), 1);
        irq_clr = 1'b1;
        step(2, 50);
        check("R7 irq acked", int'(irq_out), 0);
    endtask

    task automatic t_irq_dot_any();
        htmr_en = 1'b1; vtmr_en = 1'b0; h_cmp = 11'd100;
        step(99, 7);
        check("R6 no irq before dot", int'(irq_out), 0);
        step(100, 7);
        check("R6 irq at dot", int'(irq_out), 1);
        irq_clr = 1'b1;
        step(101, 7);
        step(100, 8);
        check("R6 irq on next line", int'(irq_out), 1);
        irq_clr = 1'b1;
        step(101, 8);
    endtask

    task automatic t_irq_dot_line();
        htmr_en = 1'b1; vtmr_en = 1'b1; h_cmp = 11'd100; v_cmp = 9'd30;
        step(100, 29);
        check("R6 no irq on other line", int'(irq_out), 0);
        step(100, 30);
        check("R6 irq at dot and line", int'(irq_out), 1);
        irq_clr = 1'b1;
        step(100, 30);
        check("R7 match beats ack", int'(irq_out), 1);
        irq_clr = 1'b1;
        step(101, 30);
        check("R7 ack after match", int'(irq_out), 0);
    endtask

    task automatic t_irq_off();
        htmr_en = 1'b0; vtmr_en = 1'b0; h_cmp = 11'd100; v_cmp = 9'd50;
        step(0, 50);
        step(100, 50);
        check("R10 no irq with timers off", int'(irq_out), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        t_reset();
        t_vblank_nmi();
        t_nmi_disabled();
        t_wrap_cancels();
        t_coincident_strobes();
        t_irq_line();
        t_irq_dot_any();
        t_irq_dot_line();
        t_irq_off();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule